// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash device and turns four simple requests into complete bus transactions: read a byte, program a byte, erase the whole chip, and ask whether the low boot region is write-locked. It drives the active-low chip-enable, output-enable and write-enable strobes itself. Each bus write keeps write-enable low for a programmable number of clock cycles, with address and data held steady around the pulse.

For a program or erase it emits the device's unlock writes, then finds the end of the internal operation by reading status back. Two methods are offered. Bit-7 polling compares bit 7 of the target byte with bit 7 of the written data. Toggle polling waits until bit 6 gives the same value on two reads in a row. A poll budget bounds the wait. Requests that cannot succeed are refused before any write reaches the device: one that would turn a stored 0 into a 1, and one that targets the boot region after a query found it locked. Each request ends with a one-cycle `done`, with `err` flagging failure, and `rd_data` carries the read result.

Top module: `flash_seq_host`

## Requirements
- R1: After reset and while idle, `idle` is 1, `done` and `err` are 0, and all three strobes (`fl_ce_n`, `fl_oe_n`, `fl_we_n`) are high.
- R2: A program request (`req_op`=1) issues exactly four writes in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then target address/target data.
- R3: Every write holds `fl_we_n` low for `cfg_we_cycles` clock cycles (0 counts as 1). During that time `fl_ce_n` is low, `fl_drive` is high, and `fl_addr`/`fl_wdata` do not change.
- R4: With `req_toggle`=0, a program completes when a read of the target address returns bit 7 equal to bit 7 of the written data. `done` never comes while the device still reports the operation busy.
- R5: With `req_toggle`=1, a program completes when two consecutive status reads return the same bit 6.
- R6: An erase request (`req_op`=2) issues six writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10. It then always uses toggle polling, whatever `req_toggle` says.
- R7: A lockout query (`req_op`=3) issues 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90, then reads address 0x0002, then writes 0x0000/0xF0. It returns `rd_data` = {7'b0, bit 0 of that read} and remembers that bit as the lock state.
- R8: Before programming, the target byte is read once. If the requested data has a 1 in any position where the stored byte has a 0, the request ends with `err`=1 and no write is issued.
- R9: While the remembered lock state is 1, a program request to 0x0000–0x1FFF ends with `err`=1 and causes no bus cycle at all (`fl_ce_n` stays high).
- R10: If `cfg_max_polls` status reads (0 counts as 1) pass without completion, the request ends with `err`=1.
- R11: A read request (`req_op`=0) performs exactly one read cycle with no writes, and returns the byte on `rd_data`.
- R12: A request is taken only while `idle` is 1. A request presented while busy is ignored. `done` is a single-cycle pulse, and `idle` follows it in the next cycle.
- R13: `fl_oe_n` and `fl_we_n` are never low together. `fl_ce_n` is low whenever either of them is low, and `fl_drive` is 0 during a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 lockout query |
| req_addr | input | 16 | Target byte address |
| req_data | input | 8 | Data to program |
| req_toggle | input | 1 | 1 selects bit-6 toggle polling, 0 selects bit-7 polling |
| cfg_we_cycles | input | WE_CNT_W | Write-enable low width in cycles |
| cfg_max_polls | input | POLL_CNT_W | Status read budget |
| idle | output | 1 | Ready for a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| rd_data | output | 8 | Read byte or lock bit |
| fl_addr | output | 16 | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_drive | output | 1 | Host drives the data bus |

## Verification
Status polling and the poll budget can both be settled by one status read. On that read the timer may expire in the same cycle that the device reports completion, or just before it does. The bench provokes this by programming with a budget of two reads while the modelled device stays busy much longer, and expects `err`. It also runs the same program with a large budget and expects success. In both cases it checks that `done` never comes while the model is still busy. A second coincidence is a new request that arrives mid-operation, in the cycles where the sequencer is between bus cycles. The bench raises one there and expects exactly one `done` and exactly four writes.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int FL_ADDR_W = 16;
    localparam int FL_DATA_W = 8;

    localparam logic [FL_ADDR_W-1:0] UNLOCK_A1   = 16'h5555;
    localparam logic [FL_ADDR_W-1:0] UNLOCK_A2   = 16'h2AAA;
    localparam logic [FL_ADDR_W-1:0] BOOT_LAST   = 16'h1FFF;
    localparam logic [FL_ADDR_W-1:0] LOCK_STAT_A = 16'h0002;
    localparam logic [FL_ADDR_W-1:0] LEAVE_ID_A  = 16'h0000;
    localparam logic [FL_DATA_W-1:0] LEAVE_ID_D  = 8'hF0;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_LOCKQ = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SETUP,
        E_ACT,
        E_HOLD
    } eng_st_e;

    typedef enum logic [2:0] {
        T_IDLE,
        T_CHECK,
        T_CMD,
        T_POLL,
        T_IDRD,
        T_EXIT,
        T_READ,
        T_DONE
    } host_st_e;

    typedef struct packed {
        logic [FL_ADDR_W-1:0] addr;
        logic [FL_DATA_W-1:0] data;
    } bus_word_t;

    // number of command writes each request emits before polling
    function automatic logic [2:0] seq_len(op_e op);
        case (op)
            OP_PROG:  return 3'd4;
            OP_ERASE: return 3'd6;
            OP_LOCKQ: return 3'd3;
            default:  return 3'd0;
        endcase
    endfunction

    // one step of the unlock/command write sequence
    function automatic bus_word_t seq_word(op_e op, logic [2:0] idx,
                                           logic [FL_ADDR_W-1:0] ta,
                                           logic [FL_DATA_W-1:0] td);
        bus_word_t w;
        w.addr = UNLOCK_A1;
        w.data = 8'hAA;
        case (idx)
            3'd0: begin w.addr = UNLOCK_A1; w.data = 8'hAA; end
            3'd1: begin w.addr = UNLOCK_A2; w.data = 8'h55; end
            3'd2: begin
                w.addr = UNLOCK_A1;
                case (op)
                    OP_PROG:  w.data = 8'hA0;
                    OP_ERASE: w.data = 8'h80;
                    default:  w.data = 8'h90;
                endcase
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    w.addr = ta;
                    w.data = td;
                end else begin
                    w.addr = UNLOCK_A1;
                    w.data = 8'hAA;
                end
            end
            3'd4: begin w.addr = UNLOCK_A2; w.data = 8'h55; end
            default: begin w.addr = UNLOCK_A1; w.data = 8'h10; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fsh_bus_engine.sv
module fsh_bus_engine
    import fsh_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 wr,
    input  logic [FL_ADDR_W-1:0] addr,
    input  logic [FL_DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]     width,
    output logic                 fin,
    output logic [FL_DATA_W-1:0] rdata,
    output logic [FL_ADDR_W-1:0] fl_addr,
    output logic [FL_DATA_W-1:0] fl_wdata,
    input  logic [FL_DATA_W-1:0] fl_rdata,
    output logic                 fl_ce_n,
    output logic                 fl_oe_n,
    output logic                 fl_we_n,
    output logic                 fl_drive
);

    eng_st_e              st;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     eff_w;
    logic [FL_ADDR_W-1:0] addr_q;
    logic [FL_DATA_W-1:0] wd_q;
    logic                 wr_q;
    logic [FL_DATA_W-1:0] rd_q;

    assign eff_w = (width == '0) ? CNT_W'(1) : width;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= E_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            wd_q   <= '0;
            wr_q   <= 1'b0;
            rd_q   <= '0;
        end else begin
            case (st)
                E_IDLE: begin
                    if (start) begin
                        addr_q <= addr;
                        wd_q   <= wdata;
                        wr_q   <= wr;
                        st     <= E_SETUP;
                    end
                end
                E_SETUP: begin
                    cnt <= CNT_W'(1);
                    st  <= E_ACT;
                end
                E_ACT: begin
                    if (cnt == eff_w) begin
                        if (!wr_q) rd_q <= fl_rdata;
                        st <= E_HOLD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    assign fin      = (st == E_HOLD);
    assign rdata    = rd_q;
    assign fl_addr  = addr_q;
    assign fl_wdata = wd_q;
    assign fl_ce_n  = (st == E_IDLE);
    assign fl_we_n  = !((st == E_ACT) && wr_q);
    assign fl_oe_n  = !((st == E_ACT) && !wr_q);
    assign fl_drive = wr_q && (st != E_IDLE);

endmodule

// File: rtl/fsh_poll_judge.sv
module fsh_poll_judge (
    input  logic toggle_mode,
    input  logic rd7,
    input  logic rd6,
    input  logic exp7,
    input  logic prev_vld,
    input  logic prev6,
    output logic complete
);

    always_comb begin
        if (toggle_mode) complete = prev_vld && (rd6 == prev6);
        else             complete = (rd7 == exp7);
    end

endmodule

// File: rtl/fsh_poll_timer.sv
module fsh_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         last
);

    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    assign eff  = (limit == '0) ? W'(1) : limit;
    assign last = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, eff};

    always_ff @(posedge clk) begin
        if (rst || clear)              cnt <= '0;
        else if (tick && cnt != '1)    cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/flash_seq_host.sv
module flash_seq_host
    import fsh_pkg::*;
#(
    parameter int WE_CNT_W   = 4,
    parameter int POLL_CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [FL_ADDR_W-1:0]  req_addr,
    input  logic [FL_DATA_W-1:0]  req_data,
    input  logic                  req_toggle,
    input  logic [WE_CNT_W-1:0]   cfg_we_cycles,
    input  logic [POLL_CNT_W-1:0] cfg_max_polls,
    output logic                  idle,
    output logic                  done,
    output logic                  err,
    output logic [FL_DATA_W-1:0]  rd_data,
    output logic [FL_ADDR_W-1:0]  fl_addr,
    output logic [FL_DATA_W-1:0]  fl_wdata,
    input  logic [FL_DATA_W-1:0]  fl_rdata,
    output logic                  fl_ce_n,
    output logic                  fl_oe_n,
    output logic                  fl_we_n,
    output logic                  fl_drive
);

    host_st_e             st;
    op_e                  op_q;
    logic [FL_ADDR_W-1:0] addr_q;
    logic [FL_DATA_W-1:0] data_q;
    logic                 tog_q;
    logic [2:0]           step;
    logic                 issued;
    logic                 prev_vld;
    logic                 prev6;
    logic                 lock_q;
    logic                 err_q;
    logic [FL_DATA_W-1:0] rdata_o;

    logic                 eng_start;
    logic                 eng_wr;
    logic [FL_ADDR_W-1:0] eng_addr;
    logic [FL_DATA_W-1:0] eng_wdata;
    logic                 eng_fin;
    logic [FL_DATA_W-1:0] eng_rd;
    logic                 poll_ok;
    logic                 poll_last;
    bus_word_t            cmd_w;
    op_e                  req_op_e;

    assign req_op_e = op_e'(req_op);
    assign cmd_w    = seq_word(op_q, step, addr_q, data_q);

    // bus request for the current state
    always_comb begin
        eng_start = 1'b0;
        eng_wr    = 1'b0;
        eng_addr  = addr_q;
        eng_wdata = data_q;
        case (st)
            T_CHECK, T_POLL, T_READ: eng_start = !issued;
            T_CMD: begin
                eng_start = !issued;
                eng_wr    = 1'b1;
                eng_addr  = cmd_w.addr;
                eng_wdata = cmd_w.data;
            end
            T_IDRD: begin
                eng_start = !issued;
                eng_addr  = LOCK_STAT_A;
            end
            T_EXIT: begin
                eng_start = !issued;
                eng_wr    = 1'b1;
                eng_addr  = LEAVE_ID_A;
                eng_wdata = LEAVE_ID_D;
            end
            default: ;
        endcase
    end

    fsh_bus_engine #(.CNT_W(WE_CNT_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .wr       (eng_wr),
        .addr     (eng_addr),
        .wdata    (eng_wdata),
        .width    (cfg_we_cycles),
        .fin      (eng_fin),
        .rdata    (eng_rd),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .fl_rdata (fl_rdata),
        .fl_ce_n  (fl_ce_n),
        .fl_oe_n  (fl_oe_n),
        .fl_we_n  (fl_we_n),
        .fl_drive (fl_drive)
    );

    fsh_poll_judge u_judge (
        .toggle_mode (tog_q),
        .rd7         (eng_rd[7]),
        .rd6         (eng_rd[6]),
        .exp7        (data_q[7]),
        .prev_vld    (prev_vld),
        .prev6       (prev6),
        .complete    (poll_ok)
    );

    fsh_poll_timer #(.W(POLL_CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (st == T_IDLE),
        .tick  ((st == T_POLL) && eng_fin),
        .limit (cfg_max_polls),
        .last  (poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= T_IDLE;
            op_q     <= OP_READ;
            addr_q   <= '0;
            data_q   <= '0;
            tog_q    <= 1'b0;
            step     <= '0;
            issued   <= 1'b0;
            prev_vld <= 1'b0;
            prev6    <= 1'b0;
            lock_q   <= 1'b0;
            err_q    <= 1'b0;
            rdata_o  <= '0;
        end else begin
            if (eng_start)    issued <= 1'b1;
            else if (eng_fin) issued <= 1'b0;

            case (st)
                T_IDLE: begin
                    if (req_valid) begin
                        op_q     <= req_op_e;
                        addr_q   <= req_addr;
                        data_q   <= req_data;
                        tog_q    <= (req_op_e == OP_ERASE) ? 1'b1 : req_toggle;
                        step     <= '0;
                        prev_vld <= 1'b0;
                        err_q    <= 1'b0;
                        case (req_op_e)
                            OP_READ: st <= T_READ;
                            OP_PROG: begin
                                if (lock_q && req_addr <= BOOT_LAST) begin
                                    err_q <= 1'b1;
                                    st    <= T_DONE;
                                end else begin
                                    st <= T_CHECK;
                                end
                            end
                            default: st <= T_CMD;
                        endcase
                    end
                end
                T_CHECK: begin
                    if (eng_fin) begin
                        if ((data_q & ~eng_rd) != '0) begin
                            err_q <= 1'b1;
                            st    <= T_DONE;
                        end else begin
                            st <= T_CMD;
                        end
                    end
                end
                T_CMD: begin
                    if (eng_fin) begin
                        if (step == seq_len(op_q) - 3'd1) begin
                            step <= '0;
                            st   <= (op_q == OP_LOCKQ) ? T_IDRD : T_POLL;
                        end else begin
                            step <= step + 3'd1;
                        end
                    end
                end
                T_POLL: begin
                    if (eng_fin) begin
                        prev_vld <= 1'b1;
                        prev6    <= eng_rd[6];
                        if (poll_ok) begin
                            st <= T_DONE;
                        end else if (poll_last) begin
                            err_q <= 1'b1;
                            st    <= T_DONE;
                        end
                    end
                end
                T_IDRD: begin
                    if (eng_fin) begin
                        rdata_o <= {7'b0, eng_rd[0]};
                        lock_q  <= eng_rd[0];
                        st      <= T_EXIT;
                    end
                end
                T_EXIT: begin
                    if (eng_fin) st <= T_DONE;
                end
                T_READ: begin
                    if (eng_fin) begin
                        rdata_o <= eng_rd;
                        st      <= T_DONE;
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign idle    = (st == T_IDLE);
    assign done    = (st == T_DONE);
    assign err     = (st == T_DONE) && err_q;
    assign rd_data = rdata_o;

endmodule

// File: rtl/fsh_host_chk.sv
module fsh_host_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             idle,
    input logic             done,
    input logic             err,
    input logic [15:0]      fl_addr,
    input logic [7:0]       fl_wdata,
    input logic             fl_ce_n,
    input logic             fl_oe_n,
    input logic             fl_we_n,
    input logic             fl_drive,
    input logic [CNT_W-1:0] cfg_we_cycles
);

    logic [CNT_W:0] run;
    logic [CNT_W:0] eff;

    assign eff = (cfg_we_cycles == '0) ? (CNT_W+1)'(1) : {1'b0, cfg_we_cycles};

    always_ff @(posedge clk) begin
        if (rst)           run <= '0;
        else if (!fl_we_n) run <= run + (CNT_W+1)'(1);
        else               run <= '0;
    end

    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(!fl_oe_n && !fl_we_n));

    p_ce_cover_r13: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

    p_read_nodrive_r13: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_drive);

    p_write_drive_r3: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> fl_drive);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> ($stable(fl_addr) && $stable(fl_wdata)));

    p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
        (fl_we_n && $past(!fl_we_n)) |-> (run == eff));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && idle));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        idle |-> (fl_ce_n && fl_we_n && fl_oe_n && !done));

endmodule

bind flash_seq_host fsh_host_chk #(.CNT_W(WE_CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .idle          (idle),
    .done          (done),
    .err           (err),
    .fl_addr       (fl_addr),
    .fl_wdata      (fl_wdata),
    .fl_ce_n       (fl_ce_n),
    .fl_oe_n       (fl_oe_n),
    .fl_we_n       (fl_we_n),
    .fl_drive      (fl_drive),
    .cfg_we_cycles (cfg_we_cycles)
);

// File: tb/flash_seq_host_tb.sv
`timescale 1ns/1ps
module flash_seq_host_tb;
    import fsh_pkg::*;

    localparam int WCW     = 4;
    localparam int PCW     = 16;
    localparam int PROG_T  = 40;
    localparam int ERASE_T = 150;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           req_valid = 1'b0;
    logic [1:0]     req_op = 2'd0;
    logic [15:0]    req_addr = '0;
    logic [7:0]     req_data = '0;
    logic           req_toggle = 1'b0;
    logic [WCW-1:0] cfg_we = 4'd2;
    logic [PCW-1:0] cfg_polls = 16'd1000;
    logic           idle, done, err;
    logic [7:0]     rd_data;
    logic [15:0]    fl_addr;
    logic [7:0]     fl_wdata, fl_rdata;
    logic           fl_ce_n, fl_oe_n, fl_we_n, fl_drive;

    flash_seq_host #(.WE_CNT_W(WCW), .POLL_CNT_W(PCW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
        .cfg_we_cycles(cfg_we), .cfg_max_polls(cfg_polls),
        .idle(idle), .done(done), .err(err), .rd_data(rd_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_drive(fl_drive)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash device model ----------------
    logic [7:0]  mem [256];
    logic [7:0]  shadow [256];
    int          busy_left = 0;
    bit          is_prog = 0;
    logic [15:0] tgt = '0;
    logic [7:0]  ld = '0;
    bit          tog = 0;
    bit          id_mode = 0;
    bit          model_lock = 0;
    int          cst = 0;
    logic [15:0] wl_a [64];
    logic [7:0]  wl_d [64];
    int          wcnt = 0;
    int          ce_falls = 0;
    int          done_cnt = 0;
    int          overlap = 0;
    int          run = 0;
    bit          p_we = 1, p_oe = 1, p_ce = 1;

    function automatic logic [7:0] midx(logic [15:0] a);
        return {a <= 16'h1FFF, a[6:0]};
    endfunction

    function automatic int exp_w();
        return (cfg_we == 0) ? 1 : int'(cfg_we);
    endfunction

    function automatic bit exp_prog_err(logic [7:0] cur, logic [7:0] d);
        return (d & ~cur) != 8'h00;
    endfunction

    assign fl_rdata = (busy_left > 0) ?
                      ((is_prog && fl_addr == tgt) ? {~ld[7], tog, 6'h00} : {1'b0, tog, 6'h00}) :
                      ((id_mode && fl_addr == 16'h0002) ? {7'b0, model_lock} : mem[midx(fl_addr)]);

    task automatic model_write(logic [15:0] a, logic [7:0] d);
        wl_a[wcnt % 64] = a;
        wl_d[wcnt % 64] = d;
        wcnt++;
        if (cst == 3) begin
            mem[midx(a)] = mem[midx(a)] & d;
            tgt = a; ld = d; is_prog = 1; busy_left = PROG_T; cst = 0;
        end else if (d == 8'hF0) begin
            id_mode = 0; cst = 0;
        end else begin
            case (cst)
                0: cst = (a == 16'h5555 && d == 8'hAA) ? 1 : 0;
                1: cst = (a == 16'h2AAA && d == 8'h55) ? 2 : 0;
                2: begin
                    if (a == 16'h5555 && d == 8'hA0) cst = 3;
                    else if (a == 16'h5555 && d == 8'h90) begin id_mode = 1; cst = 0; end
                    else if (a == 16'h5555 && d == 8'h80) cst = 4;
                    else cst = 0;
                end
                4: cst = (a == 16'h5555 && d == 8'hAA) ? 5 : 0;
                5: cst = (a == 16'h2AAA && d == 8'h55) ? 6 : 0;
                6: begin
                    if (a == 16'h5555 && d == 8'h10) begin
                        for (int i = 0; i < 256; i++)
                            if (!(model_lock && i[7])) mem[i] = 8'hFF;
                        is_prog = 0; busy_left = ERASE_T;
                    end
                    cst = 0;
                end
                default: cst = 0;
            endcase
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            p_we = 1; p_oe = 1; p_ce = 1; run = 0;
        end else begin
            if (busy_left > 0) busy_left--;
            if (done) done_cnt++;
            if (!fl_oe_n && !fl_we_n) overlap++;
            if (!fl_ce_n && p_ce) ce_falls++;
            if (!fl_oe_n && p_oe && busy_left > 0) tog = ~tog;
            if (!fl_we_n) run++;
            else if (!p_we) begin
                check(run == exp_w(), "R3 write-enable low width", run, exp_w());
                run = 0;
                model_write(fl_addr, fl_wdata);
            end
            p_we = fl_we_n; p_oe = fl_oe_n; p_ce = fl_ce_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic do_req(op_e op, logic [15:0] a, logic [7:0] d, bit tgl,
                          output bit e, output logic [7:0] r);
        while (!idle) @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_toggle = tgl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        e = err;
        r = rd_data;
        @(negedge clk);
    endtask

    task automatic chk_w(int idx, logic [15:0] ea, logic [7:0] ed, string tag);
        check(wl_a[idx % 64] == ea && wl_d[idx % 64] == ed, tag,
              {wl_a[idx % 64], wl_d[idx % 64]}, {ea, ed});
    endtask

    task automatic run_prog(logic [15:0] a, logic [7:0] d, bit tgl, string tag);
        bit e; logic [7:0] r; int w0;
        w0 = wcnt;
        do_req(OP_PROG, a, d, tgl, e, r);
        check(e == 0, {tag, " program err"}, e, 0);
        check(busy_left == 0, {tag, " done only after device ready"}, busy_left, 0);
        check(wcnt - w0 == 4, "R2 program write count", wcnt - w0, 4);
        chk_w(w0 + 0, 16'h5555, 8'hAA, "R2 write 1");
        chk_w(w0 + 1, 16'h2AAA, 8'h55, "R2 write 2");
        chk_w(w0 + 2, 16'h5555, 8'hA0, "R2 write 3");
        chk_w(w0 + 3, a, d, "R2 write 4");
        shadow[midx(a)] = shadow[midx(a)] & d;
        do_req(OP_READ, a, 8'h00, 0, e, r);
        check(r == shadow[midx(a)], {tag, " programmed value"}, r, shadow[midx(a)]);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        bit e; logic [7:0] r; int w0, c0, d0; logic [15:0] a; logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(idle == 1 && done == 0 && err == 0, "R1 reset idle/done/err", {idle, done, err}, 3'b100);
        check(fl_ce_n && fl_oe_n && fl_we_n, "R1 reset strobes high", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);

        // R11 plain read
        w0 = wcnt; c0 = ce_falls;
        do_req(OP_READ, 16'h4005, 8'h00, 0, e, r);
        check(r == shadow[midx(16'h4005)], "R11 read data", r, shadow[midx(16'h4005)]);
        check(wcnt == w0 && ce_falls - c0 == 1, "R11 one read cycle, no write", ce_falls - c0, 1);

        // R4 bit-7 polling, R5 toggle polling
        run_prog(16'h4010, shadow[midx(16'h4010)] & 8'h5A, 0, "R4");
        run_prog(16'h4020, shadow[midx(16'h4020)] & 8'hA5, 1, "R5");

        // R8 zero-to-one refused
        mem[midx(16'h4030)] = 8'h3C; shadow[midx(16'h4030)] = 8'h3C;
        w0 = wcnt; c0 = ce_falls;
        do_req(OP_PROG, 16'h4030, 8'h7C, 0, e, r);
        check(e == exp_prog_err(8'h3C, 8'h7C), "R8 zero-to-one err", e, 1);
        check(wcnt == w0 && ce_falls - c0 == 1, "R8 only precheck read issued", wcnt - w0, 0);
        do_req(OP_READ, 16'h4030, 8'h00, 0, e, r);
        check(r == 8'h3C, "R8 byte unchanged", r, 8'h3C);

        // R10 poll budget exhausted
        cfg_polls = 16'd2;
        d = shadow[midx(16'h4040)] & 8'h0F;
        do_req(OP_PROG, 16'h4040, d, 0, e, r);
        check(e == 1, "R10 poll timeout err", e, 1);
        shadow[midx(16'h4040)] = d;
        repeat (PROG_T + 10) @(negedge clk);
        cfg_polls = 16'd1000;

        // R3 widths 0 (as 1) and 5
        cfg_we = 4'd0;
        run_prog(16'h4050, shadow[midx(16'h4050)] & 8'h33, 0, "R3 w0");
        cfg_we = 4'd5;
        run_prog(16'h4060, shadow[midx(16'h4060)] & 8'hCC, 1, "R3 w5");
        cfg_we = 4'd2;

        // R7 lockout query, unlocked
        w0 = wcnt;
        do_req(OP_LOCKQ, 16'h0000, 8'h00, 0, e, r);
        check(r == 8'h00 && e == 0, "R7 query unlocked", r, 0);
        check(wcnt - w0 == 4, "R7 query write count", wcnt - w0, 4);
        chk_w(w0 + 0, 16'h5555, 8'hAA, "R7 write 1");
        chk_w(w0 + 1, 16'h2AAA, 8'h55, "R7 write 2");
        chk_w(w0 + 2, 16'h5555, 8'h90, "R7 write 3");
        chk_w(w0 + 3, 16'h0000, 8'hF0, "R7 exit write");
        do_req(OP_READ, 16'h0002, 8'h00, 0, e, r);
        check(r == shadow[midx(16'h0002)], "R7 id mode left", r, shadow[midx(16'h0002)]);

        // R12 request while busy ignored
        w0 = wcnt; d0 = done_cnt;
        d = shadow[midx(16'h4070)] & 8'h0F;
        while (!idle) @(negedge clk);
        req_op = OP_PROG; req_addr = 16'h4070; req_data = d; req_toggle = 0; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        req_op = OP_READ; req_addr = 16'h4005; req_valid = 1;
        repeat (2) @(negedge clk);
        req_valid = 0;
        while (!done) @(negedge clk);
        e = err;
        repeat (4) @(negedge clk);
        shadow[midx(16'h4070)] = d;
        check(done_cnt - d0 == 1 && e == 0, "R12 one done for busy-time request", done_cnt - d0, 1);
        check(wcnt - w0 == 4 && idle, "R12 extra request not issued", wcnt - w0, 4);

        // R7/R9 lock active
        model_lock = 1;
        do_req(OP_LOCKQ, 16'h0000, 8'h00, 0, e, r);
        check(r == 8'h01, "R7 query locked", r, 1);
        w0 = wcnt; c0 = ce_falls;
        do_req(OP_PROG, 16'h0011, 8'h00, 0, e, r);
        check(e == 1, "R9 boot program refused", e, 1);
        check(ce_falls == c0 && wcnt == w0, "R9 no bus cycle", ce_falls - c0, 0);
        run_prog(16'h4011, shadow[midx(16'h4011)] & 8'hF0, 0, "R9 main allowed");

        // R6 erase with req_toggle=0 forced to toggle
        w0 = wcnt;
        do_req(OP_ERASE, 16'h4000, 8'h00, 0, e, r);
        check(e == 0 && busy_left == 0, "R6 erase completes after device ready", busy_left, 0);
        check(wcnt - w0 == 6, "R6 erase write count", wcnt - w0, 6);
        chk_w(w0 + 0, 16'h5555, 8'hAA, "R6 write 1");
        chk_w(w0 + 1, 16'h2AAA, 8'h55, "R6 write 2");
        chk_w(w0 + 2, 16'h5555, 8'h80, "R6 write 3");
        chk_w(w0 + 3, 16'h5555, 8'hAA, "R6 write 4");
        chk_w(w0 + 4, 16'h2AAA, 8'h55, "R6 write 5");
        chk_w(w0 + 5, 16'h5555, 8'h10, "R6 write 6");
        for (int i = 0; i < 256; i++)
            if (!(model_lock && i[7])) shadow[i] = 8'hFF;
        do_req(OP_READ, 16'h4020, 8'h00, 0, e, r);
        check(r == 8'hFF, "R6 main erased", r, 8'hFF);
        do_req(OP_READ, 16'h0011, 8'h00, 0, e, r);
        check(r == shadow[midx(16'h0011)], "R6 locked boot kept", r, shadow[midx(16'h0011)]);

        // random mix of reads and programs in main area
        for (int k = 0; k < 40; k++) begin
            bit expe;
            a = 16'h4000 | 16'($urandom_range(0, 127));
            if ($urandom_range(0, 2) == 0) begin
                do_req(OP_READ, a, 8'h00, 0, e, r);
                check(r == shadow[midx(a)], "R11 random read", r, shadow[midx(a)]);
            end else begin
                d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (shadow[midx(a)] & 8'($urandom));
                expe = exp_prog_err(shadow[midx(a)], d);
                do_req(OP_PROG, a, d, bit'($urandom_range(0, 1)), e, r);
                check(e == expe, "R8 random program err", e, expe);
                if (!expe) shadow[midx(a)] = d;
                check(mem[midx(a)] == shadow[midx(a)], "R4 random stored byte", mem[midx(a)], shadow[midx(a)]);
            end
        end

        check(overlap == 0, "R13 strobe overlap", overlap, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule